// File: doc/BRIEF.md
# SDRAM command sequencer

This block is the memory-side state machine that sits between a host-interface block and a 2M x 32 SDRAM with four banks, clocked at 100 to 125 MHz. After reset it runs the power-up sequence. During the settle time it keeps the device deselected. It then precharges all banks, issues two auto-refresh commands, pulses a strobe so that the host side loads its default mode-register value, and programs the mode register. Once this is done it serves one transfer at a time and inserts auto-refresh commands at a fixed interval.

Requests arrive as three level signals: read, write and mode set. Each request is held until its matching acknowledge pulses. The sequencer never forms addresses itself. For every command it drives two 2-bit select codes, and the host side uses them to steer row, column, mode-register or constant values onto the multiplexed address lines. The bank bits follow the row and column codes. The sequencer also times the read-data capture strobe from the CAS latency that the host side holds in its mode register. While a refresh is in progress it raises a busy flag, which the host side uses to stall a selected host.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the outputs follow a fixed order. First come INIT_WAIT_CYC cycles with the chip deselected. Then a PRECHARGE-all and T_RP-1 NOPs. Then two REFRESH commands, each followed by T_RFC-1 NOPs. Then one NOP cycle with loadDefault high. Last comes a MODE SET and T_MRD-1 NOPs. Requests held during this whole sequence get no acknowledge.
- R2: The pins {csN,rasN,casN,weN} carry these codes: deselect 1111, NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE SET 0000.
- R3: An access opens with ACTIVE (hiSel 0 = row MSB, loSel 0 = row). T_RCD-1 NOPs follow. Then comes READ or WRITE with hiSel 1 (forced 0, no auto-precharge) and loSel 1 (column).
- R4: rdCapture is high for exactly one cycle, CL cycles after the READ cycle. CL is casLat, and a casLat of 0 counts as 1.
- R5: The cycle after the capture carries PRECHARGE-all (hiSel 3 = forced 1, loSel 3 = zeros) with ackRead high. T_RP-1 NOPs follow before the block is idle. No two acknowledges are ever high together.
- R6: After WRITE, exactly T_WR NOPs pass before a PRECHARGE-all that carries ackWrite. T_RP-1 NOPs follow.
- R7: A mode-set request produces MODE SET with hiSel 2 and loSel 2 and ackModeSet in the same cycle. T_MRD-1 NOPs follow.
- R8: A refresh becomes due at every REFRESH_INTERVAL-th clock edge after reset is released. A due refresh is served only from idle, as REFRESH, and never inside an access. Several due refreshes that have not been served count as one.
- R9: refreshBusy is high during every REFRESH cycle and the T_RFC-1 cycles after it, and low at all other times.
- R10: When the block is idle and several sources are pending, it serves them in this order: a due refresh first, then read, then write, then mode set.
- R11: An idle cycle drives NOP with hiSel 1 and loSel 3. A request sampled at the clock edge that ends an idle cycle starts its command in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqRead | input | 1 | Read request level, held until ackRead |
| reqWrite | input | 1 | Write request level, held until ackWrite |
| reqModeSet | input | 1 | Mode-set request level, held until ackModeSet |
| casLat | input | 3 | CAS latency from the host-side mode register |
| ackRead | output | 1 | One-cycle read acknowledge |
| ackWrite | output | 1 | One-cycle write acknowledge |
| ackModeSet | output | 1 | One-cycle mode-set acknowledge |
| loadDefault | output | 1 | Strobe that tells the host side to load its default mode value |
| csN | output | 1 | SDRAM chip select, active low |
| rasN | output | 1 | SDRAM row strobe, active low |
| casN | output | 1 | SDRAM column strobe, active low |
| weN | output | 1 | SDRAM write enable, active low |
| hiSel | output | 2 | Select code for address bit 10 |
| loSel | output | 2 | Select code for address bits 9:0 |
| rdCapture | output | 1 | Read-data capture strobe |
| refreshBusy | output | 1 | Refresh in progress |

## Verification
Two things can fall due in the same idle cycle: the refresh timer and a newly raised request. A refresh that is due must win, and the request must wait until the refresh recovery is over. The bench counts clock edges from reset release. Using that count, it raises requests exactly at the edge where a refresh becomes visible, and also one edge earlier. Its behavioural model applies the priority to every cycle and compares the full pin and strobe vector on each clock. Read and write, and write and mode set, are also raised together, so that the request order is judged as well.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_READ,
    CMD_WRITE,
    CMD_PRE,
    CMD_REF,
    CMD_MRS,
    CMD_DESEL
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    cmd_e cmd;
    logic refTake;
  } seq_strobe_t;

  // upper address bit select codes
  localparam logic [1:0] HI_ROWMSB = 2'd0;
  localparam logic [1:0] HI_ZERO   = 2'd1;
  localparam logic [1:0] HI_MODE   = 2'd2;
  localparam logic [1:0] HI_ONE    = 2'd3;

  // lower address field select codes
  localparam logic [1:0] LO_ROW    = 2'd0;
  localparam logic [1:0] LO_COL    = 2'd1;
  localparam logic [1:0] LO_MODE   = 2'd2;
  localparam logic [1:0] LO_ZERO   = 2'd3;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdseq_dpath.sv
module sdseq_dpath
  import sdseq_pkg::*;
#(
  parameter int REFRESH_INTERVAL = 1560,
  parameter int CL_W             = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  seq_strobe_t     strobe,
  input  logic [CL_W-1:0] casLat,
  output logic            csN,
  output logic            rasN,
  output logic            casN,
  output logic            weN,
  output logic [1:0]      hiSel,
  output logic [1:0]      loSel,
  output logic            refDue,
  output logic            rdCapture
);

  localparam int REF_W  = $clog2(REFRESH_INTERVAL);
  localparam int PIPE_D = (1 << CL_W) - 1;

  // command pin and select decode
  always_comb begin
    {csN, rasN, casN, weN} = 4'b0111;
    hiSel = HI_ZERO;
    loSel = LO_ZERO;
    unique case (strobe.cmd)
      CMD_ACT:   begin {csN, rasN, casN, weN} = 4'b0011; hiSel = HI_ROWMSB; loSel = LO_ROW;  end
      CMD_READ:  begin {csN, rasN, casN, weN} = 4'b0101; hiSel = HI_ZERO;   loSel = LO_COL;  end
      CMD_WRITE: begin {csN, rasN, casN, weN} = 4'b0100; hiSel = HI_ZERO;   loSel = LO_COL;  end
      CMD_PRE:   begin {csN, rasN, casN, weN} = 4'b0010; hiSel = HI_ONE;    loSel = LO_ZERO; end
      CMD_REF:   begin {csN, rasN, casN, weN} = 4'b0001; end
      CMD_MRS:   begin {csN, rasN, casN, weN} = 4'b0000; hiSel = HI_MODE;   loSel = LO_MODE; end
      CMD_DESEL: begin {csN, rasN, casN, weN} = 4'b1111; end
      default:   begin {csN, rasN, casN, weN} = 4'b0111; end
    endcase
  end

  // refresh interval timer with one remembered request
  logic [REF_W-1:0] refCnt;
  logic             refPending;
  logic             refHit;

  assign refHit = (refCnt == REF_W'(REFRESH_INTERVAL - 1));
  assign refDue = refPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      refCnt <= refHit ? '0 : refCnt + REF_W'(1);
      if (refHit)
        refPending <= 1'b1;
      else if (strobe.refTake)
        refPending <= 1'b0;
    end
  end

  // read issue delay line, tapped by CAS latency
  logic [PIPE_D-1:0] rdPipe;
  logic              rdIssue;
  logic              pipeClr;

  assign rdIssue = (strobe.cmd == CMD_READ);
  assign pipeClr = (strobe.cmd == CMD_PRE);

  for (genvar g = 0; g < PIPE_D; g++) begin : g_rdPipe
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        rdPipe[g] <= 1'b0;
        else if (pipeClr) rdPipe[g] <= 1'b0;
        else              rdPipe[g] <= rdIssue;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        rdPipe[g] <= 1'b0;
        else if (pipeClr) rdPipe[g] <= 1'b0;
        else              rdPipe[g] <= rdPipe[g-1];
      end
    end
  end

  logic [CL_W-1:0] effCl;
  assign effCl = (casLat == '0) ? CL_W'(1) : casLat;

  always_comb begin
    rdCapture = 1'b0;
    for (int i = 0; i < PIPE_D; i++) begin
      if (effCl == CL_W'(i + 1)) rdCapture = rdPipe[i];
    end
  end

  // a due refresh stays due until control takes it
  assert_pending_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (refPending && !strobe.refTake) |=> refPending);

endmodule

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
  import sdseq_pkg::*;
#(
  parameter int INIT_WAIT_CYC = 10000,
  parameter int T_RCD         = 2,
  parameter int T_RP          = 2,
  parameter int T_RFC         = 7,
  parameter int T_WR          = 2,
  parameter int T_MRD         = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqRead,
  input  logic        reqWrite,
  input  logic        reqModeSet,
  input  logic        refDue,
  input  logic        rdCapture,
  output seq_strobe_t strobe,
  output logic        ackRead,
  output logic        ackWrite,
  output logic        ackModeSet,
  output logic        loadDefault,
  output logic        refreshBusy
);

  localparam int MAX_GAP = imax(imax(INIT_WAIT_CYC, T_RFC), imax(imax(T_RCD, T_RP), imax(T_WR, T_MRD)));
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  typedef enum logic [3:0] {
    S_WAIT, S_INIT_PRE, S_INIT_REF1, S_INIT_REF2, S_INIT_LOAD, S_INIT_MRS,
    S_IDLE, S_ACT, S_RD, S_RD_WAIT, S_WR, S_PRE, S_REF, S_MRS
  } state_e;

  state_e           state, stateN, retState, retN, after;
  logic [CNT_W-1:0] waitCnt, cntN, gapV;
  logic             opRead, opReadN;
  logic             busyRef, busyRefN;
  logic             doGap;

  always_comb begin
    stateN         = state;
    retN           = retState;
    cntN           = waitCnt;
    opReadN        = opRead;
    doGap          = 1'b0;
    gapV           = '0;
    after          = S_IDLE;
    strobe.cmd     = CMD_NOP;
    strobe.refTake = 1'b0;
    ackRead        = 1'b0;
    ackWrite       = 1'b0;
    ackModeSet     = 1'b0;
    loadDefault    = 1'b0;
    unique case (state)
      S_WAIT: begin
        strobe.cmd = (retState == S_INIT_PRE) ? CMD_DESEL : CMD_NOP;
        if (waitCnt == '0) stateN = retState;
        else               cntN   = waitCnt - CNT_W'(1);
      end
      S_INIT_PRE: begin
        strobe.cmd = CMD_PRE;
        doGap = 1'b1; gapV = CNT_W'(T_RP - 1); after = S_INIT_REF1;
      end
      S_INIT_REF1: begin
        strobe.cmd = CMD_REF;
        doGap = 1'b1; gapV = CNT_W'(T_RFC - 1); after = S_INIT_REF2;
      end
      S_INIT_REF2: begin
        strobe.cmd = CMD_REF;
        doGap = 1'b1; gapV = CNT_W'(T_RFC - 1); after = S_INIT_LOAD;
      end
      S_INIT_LOAD: begin
        loadDefault = 1'b1;
        stateN      = S_INIT_MRS;
      end
      S_INIT_MRS: begin
        strobe.cmd = CMD_MRS;
        doGap = 1'b1; gapV = CNT_W'(T_MRD - 1); after = S_IDLE;
      end
      S_IDLE: begin
        if (refDue) begin
          stateN         = S_REF;
          strobe.refTake = 1'b1;
        end else if (reqRead) begin
          stateN  = S_ACT;
          opReadN = 1'b1;
        end else if (reqWrite) begin
          stateN  = S_ACT;
          opReadN = 1'b0;
        end else if (reqModeSet) begin
          stateN  = S_MRS;
        end
      end
      S_ACT: begin
        strobe.cmd = CMD_ACT;
        doGap = 1'b1; gapV = CNT_W'(T_RCD - 1); after = opRead ? S_RD : S_WR;
      end
      S_RD: begin
        strobe.cmd = CMD_READ;
        stateN     = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        if (rdCapture) stateN = S_PRE;
      end
      S_WR: begin
        strobe.cmd = CMD_WRITE;
        doGap = 1'b1; gapV = CNT_W'(T_WR); after = S_PRE;
      end
      S_PRE: begin
        strobe.cmd = CMD_PRE;
        ackRead    = opRead;
        ackWrite   = !opRead;
        doGap = 1'b1; gapV = CNT_W'(T_RP - 1); after = S_IDLE;
      end
      S_REF: begin
        strobe.cmd = CMD_REF;
        doGap = 1'b1; gapV = CNT_W'(T_RFC - 1); after = S_IDLE;
      end
      S_MRS: begin
        strobe.cmd = CMD_MRS;
        ackModeSet = 1'b1;
        doGap = 1'b1; gapV = CNT_W'(T_MRD - 1); after = S_IDLE;
      end
      default: stateN = S_IDLE;
    endcase
    if (doGap) begin
      if (gapV == '0) begin
        stateN = after;
      end else begin
        stateN = S_WAIT;
        cntN   = gapV - CNT_W'(1);
        retN   = after;
      end
    end
  end

  assign busyRefN = (stateN == S_REF) || (stateN == S_INIT_REF1) || (stateN == S_INIT_REF2) ||
                    (busyRef && stateN == S_WAIT);
  assign refreshBusy = busyRef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_WAIT;
      retState <= S_INIT_PRE;
      waitCnt  <= CNT_W'(INIT_WAIT_CYC - 1);
      opRead   <= 1'b0;
      busyRef  <= 1'b0;
    end else begin
      state    <= stateN;
      retState <= retN;
      waitCnt  <= cntN;
      opRead   <= opReadN;
      busyRef  <= busyRefN;
    end
  end

  // refresh only ever follows an idle cycle
  assert_ref_from_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REF) |-> ($past(state) == S_IDLE));

  // the default-load strobe directly precedes the power-up mode set
  assert_load_before_mrs_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_INIT_MRS) |-> $past(loadDefault));

  // a capture while waiting closes the read at the next edge
  assert_cap_closes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RD_WAIT && rdCapture) |=> (state == S_PRE));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int INIT_WAIT_CYC    = 10000,
  parameter int REFRESH_INTERVAL = 1560,
  parameter int T_RCD            = 2,
  parameter int T_RP             = 2,
  parameter int T_RFC            = 7,
  parameter int T_WR             = 2,
  parameter int T_MRD            = 2,
  parameter int CL_W             = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqRead,
  input  logic            reqWrite,
  input  logic            reqModeSet,
  input  logic [CL_W-1:0] casLat,
  output logic            ackRead,
  output logic            ackWrite,
  output logic            ackModeSet,
  output logic            loadDefault,
  output logic            csN,
  output logic            rasN,
  output logic            casN,
  output logic            weN,
  output logic [1:0]      hiSel,
  output logic [1:0]      loSel,
  output logic            rdCapture,
  output logic            refreshBusy
);

  seq_strobe_t strobe;
  logic        refDue;

  sdseq_ctrl #(
    .INIT_WAIT_CYC(INIT_WAIT_CYC), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_WR(T_WR), .T_MRD(T_MRD)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqRead(reqRead), .reqWrite(reqWrite), .reqModeSet(reqModeSet),
    .refDue(refDue), .rdCapture(rdCapture),
    .strobe(strobe),
    .ackRead(ackRead), .ackWrite(ackWrite), .ackModeSet(ackModeSet),
    .loadDefault(loadDefault), .refreshBusy(refreshBusy)
  );

  sdseq_dpath #(
    .REFRESH_INTERVAL(REFRESH_INTERVAL), .CL_W(CL_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .casLat(casLat),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .hiSel(hiSel), .loSel(loSel),
    .refDue(refDue), .rdCapture(rdCapture)
  );

  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ackRead, ackWrite, ackModeSet}));

  // transfer acknowledges ride on a precharge at the pins
  assert_ack_on_pre_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead || ackWrite) |-> ({csN, rasN, casN, weN} == 4'b0010));

  // a refresh command at the pins is always flagged busy
  assert_busy_on_ref_R9: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} == 4'b0001) |-> refreshBusy);

endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;

  localparam int INIT_W = 20;
  localparam int REF_I  = 120;
  localparam int TRCD   = 2;
  localparam int TRP    = 2;
  localparam int TRFC   = 4;
  localparam int TWR    = 2;
  localparam int TMRD   = 2;

  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5, C_MRS = 6, C_DES = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, reqRead, reqWrite, reqModeSet;
  logic [2:0] casLat;
  logic       ackRead, ackWrite, ackModeSet, loadDefault;
  logic       csN, rasN, casN, weN, rdCapture, refreshBusy;
  logic [1:0] hiSel, loSel;

  sdram_cmd_seq #(
    .INIT_WAIT_CYC(INIT_W), .REFRESH_INTERVAL(REF_I), .T_RCD(TRCD), .T_RP(TRP),
    .T_RFC(TRFC), .T_WR(TWR), .T_MRD(TMRD), .CL_W(3)
  ) i_sdram_cmd_seq (
    .clk(clk), .rstN(rstN), .reqRead(reqRead), .reqWrite(reqWrite), .reqModeSet(reqModeSet),
    .casLat(casLat), .ackRead(ackRead), .ackWrite(ackWrite), .ackModeSet(ackModeSet),
    .loadDefault(loadDefault), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .hiSel(hiSel), .loSel(loSel), .rdCapture(rdCapture), .refreshBusy(refreshBusy)
  );

  typedef struct {
    logic [13:0] v;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   vecs = 0;
  int   bad  = 0;
  int   cycC = 0;
  int   refCnt = 0;
  bit   pending = 0;
  bit   takeRef;
  bit   done = 0;
  int   nsrc;
  int   effCl;
  string tg;

  // expected vector: {csN,rasN,casN,weN,hiSel,loSel,ackR,ackW,ackM,cap,busy,load}
  function automatic logic [13:0] mk(input int c, input bit ar, input bit aw, input bit am,
                                     input bit cap, input bit busy, input bit ld);
    logic [3:0] p;
    logic [1:0] h, l;
    h = 2'd1; l = 2'd3;
    case (c)
      C_ACT:   begin p = 4'b0011; h = 2'd0; l = 2'd0; end
      C_RD:    begin p = 4'b0101; h = 2'd1; l = 2'd1; end
      C_WR:    begin p = 4'b0100; h = 2'd1; l = 2'd1; end
      C_PRE:   begin p = 4'b0010; h = 2'd3; l = 2'd3; end
      C_REF:   p = 4'b0001;
      C_MRS:   begin p = 4'b0000; h = 2'd2; l = 2'd2; end
      C_DES:   p = 4'b1111;
      default: p = 4'b0111;
    endcase
    return {p, h, l, ar, aw, am, cap, busy, ld};
  endfunction

  task automatic push(input logic [13:0] v, input string t, input int n);
    for (int i = 0; i < n; i++) q.push_back('{v, t});
  endtask

  // behavioural reference: queue of per-cycle expectations
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete();
      pending = 0;
      refCnt  = 0;
      cycC    = 0;
      push(mk(C_DES, 0, 0, 0, 0, 0, 0), "R1", INIT_W);
      push(mk(C_PRE, 0, 0, 0, 0, 0, 0), "R1", 1);
      push(mk(C_NOP, 0, 0, 0, 0, 0, 0), "R1", TRP - 1);
      for (int k = 0; k < 2; k++) begin
        push(mk(C_REF, 0, 0, 0, 0, 1, 0), "R9", 1);
        push(mk(C_NOP, 0, 0, 0, 0, 1, 0), "R9", TRFC - 1);
      end
      push(mk(C_NOP, 0, 0, 0, 0, 0, 1), "R1", 1);
      push(mk(C_MRS, 0, 0, 0, 0, 0, 0), "R1", 1);
      push(mk(C_NOP, 0, 0, 0, 0, 0, 0), "R1", TMRD - 1);
    end else begin
      cycC++;
      takeRef = 0;
      if (q.size() == 0) begin
        nsrc = int'(pending) + int'(reqRead) + int'(reqWrite) + int'(reqModeSet);
        effCl = (casLat == 0) ? 1 : int'(casLat);
        if (pending) begin
          tg = (nsrc > 1) ? "R10" : "R8";
          push(mk(C_REF, 0, 0, 0, 0, 1, 0), tg, 1);
          push(mk(C_NOP, 0, 0, 0, 0, 1, 0), "R9", TRFC - 1);
          takeRef = 1;
        end else if (reqRead) begin
          tg = (nsrc > 1) ? "R10" : "R3";
          push(mk(C_ACT, 0, 0, 0, 0, 0, 0), tg, 1);
          push(mk(C_NOP, 0, 0, 0, 0, 0, 0), "R3", TRCD - 1);
          push(mk(C_RD, 0, 0, 0, 0, 0, 0), tg, 1);
          push(mk(C_NOP, 0, 0, 0, 0, 0, 0), "R4", effCl - 1);
          push(mk(C_NOP, 0, 0, 0, 1, 0, 0), "R4", 1);
          push(mk(C_PRE, 1, 0, 0, 0, 0, 0), "R5", 1);
          push(mk(C_NOP, 0, 0, 0, 0, 0, 0), "R5", TRP - 1);
        end else if (reqWrite) begin
          tg = (nsrc > 1) ? "R10" : "R6";
          push(mk(C_ACT, 0, 0, 0, 0, 0, 0), tg, 1);
          push(mk(C_NOP, 0, 0, 0, 0, 0, 0), "R3", TRCD - 1);
          push(mk(C_WR, 0, 0, 0, 0, 0, 0), tg, 1);
          push(mk(C_NOP, 0, 0, 0, 0, 0, 0), "R6", TWR);
          push(mk(C_PRE, 0, 1, 0, 0, 0, 0), "R6", 1);
          push(mk(C_NOP, 0, 0, 0, 0, 0, 0), "R6", TRP - 1);
        end else if (reqModeSet) begin
          push(mk(C_MRS, 0, 0, 1, 0, 0, 0), "R7", 1);
          push(mk(C_NOP, 0, 0, 0, 0, 0, 0), "R7", TMRD - 1);
        end
      end else begin
        void'(q.pop_front());
      end
      if (refCnt == REF_I - 1) begin
        refCnt  = 0;
        pending = 1;
      end else begin
        refCnt++;
        if (takeRef) pending = 0;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      exp_t e;
      logic [13:0] act;
      e   = (q.size() > 0) ? q[0] : '{mk(C_NOP, 0, 0, 0, 0, 0, 0), "R11"};
      act = {csN, rasN, casN, weN, hiSel, loSel, ackRead, ackWrite, ackModeSet,
             rdCapture, refreshBusy, loadDefault};
      vecs++;
      if (act !== e.v) begin
        bad++;
        $display("FAIL %s: cycle %0d got %b expected %b", e.tag, cycC, act, e.v);
      end
    end
  end

  task automatic waitAck(input int which);
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      if ((which == 0 && ackRead) || (which == 1 && ackWrite) || (which == 2 && ackModeSet)) break;
      if (n > 5000) break;
    end
  endtask

  task automatic xfer(input int kind, input int gap);
    if (kind == 0) reqRead = 1'b1;
    else if (kind == 1) reqWrite = 1'b1;
    else reqModeSet = 1'b1;
    waitAck(kind);
    reqRead = 1'b0; reqWrite = 1'b0; reqModeSet = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    finishRun();
  end

  initial begin
    int unsigned seed;
    int tgt;
    rstN = 1'b0; reqRead = 1'b0; reqWrite = 1'b0; reqModeSet = 1'b0; casLat = 3'd2;
    repeat (3) @(negedge clk);
    // reset state checks
    vecs++;
    if ({csN, rasN, casN, weN} !== 4'b1111) begin
      bad++; $display("FAIL R2: reset pins got %b expected 1111", {csN, rasN, casN, weN});
    end
    vecs++;
    if ({ackRead, ackWrite, ackModeSet, loadDefault, refreshBusy, rdCapture} !== 6'b0) begin
      bad++; $display("FAIL R1: reset strobes got %b expected 000000",
                      {ackRead, ackWrite, ackModeSet, loadDefault, refreshBusy, rdCapture});
    end
    #5 rstN = 1'b1;
    // R1: request held through power-up must wait
    reqRead = 1'b1;
    waitAck(0);
    reqRead = 1'b0;
    repeat (4) @(negedge clk);

    xfer(1, 4);                  // R6 write
    xfer(2, 4);                  // R7 mode set
    casLat = 3'd3; xfer(0, 4);   // R4 latency 3
    casLat = 3'd1; xfer(0, 4);   // R4 latency 1
    casLat = 3'd0; xfer(0, 4);   // R4 latency 0 treated as 1
    casLat = 3'd2; xfer(0, 0);   // R11 back-to-back
    xfer(1, 0);

    // R10: read and write together
    reqRead = 1'b1; reqWrite = 1'b1;
    waitAck(0); reqRead = 1'b0;
    waitAck(1); reqWrite = 1'b0;
    repeat (3) @(negedge clk);
    // R10: write and mode set together
    reqWrite = 1'b1; reqModeSet = 1'b1;
    waitAck(1); reqWrite = 1'b0;
    waitAck(2); reqModeSet = 1'b0;
    repeat (3) @(negedge clk);

    // R8 / R10: requests placed on the edge where a refresh falls due
    for (int k = 0; k < 4; k++) begin
      tgt = ((cycC + 30) / REF_I + 1) * REF_I - (k % 2);
      while (cycC < tgt) @(negedge clk);
      xfer(k % 3, 3);
    end

    // mixed traffic with varied gaps
    seed = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      xfer(int'((seed >> 16) % 3), int'((seed >> 8) % 7));
    end

    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule